// File: doc/BRIEF.md
# PCID-tagged TLB invalidation engine

This block is a small fully associative translation buffer. Each slot holds a virtual page number, a physical page number, a page-size code, a 12-bit process-context tag and a global flag. A combinational lookup port translates an address for a given context, and a fill port installs new translations. A third port accepts invalidation requests made of a 64-bit scope selector and a 128-bit descriptor.

An accepted request is checked first. If it breaks a rule, the block pulses a fault and changes nothing. If it passes, the engine visits one slot per cycle and clears every slot that the selected scope covers, then pulses done. While the sweep runs, lookups report a miss and fills are dropped.

A context-enable input models the mode in which only context 0 is cached. In that mode, fills and lookups use context 0, and the sweeping scopes touch only context-0 slots.

Top module: `pcid_tlb`

## Requirements
- R1: After reset, no slot is valid, so every lookup misses, and `busy`, `inv_done` and `inv_fault` are all low.
- R2: A fill that arrives while `busy` is low goes into the lowest-numbered free slot. If no slot is free, it goes into the slot named by a wrapping victim pointer, which starts at 0 and advances on each such fill. A lookup hits a valid slot that is global or whose context equals the lookup context. The page number is compared above the page-offset bits of that slot's size code: 0 is 4 KiB, 1 is 2 MiB (9 more bits ignored), 2 is 1 GiB (18 more bits ignored). The lowest-numbered hit supplies `lk_ppn`, with the ignored low bits taken from the lookup address. While `pcid_en` is low, fills store context 0 and lookups use context 0.
- R3: A request faults if any bit of `inv_type[63:2]` is set, or if any bit of descriptor field [63:12] is set. The fault pulse on `inv_fault` comes one cycle after acceptance, `busy` stays low, and no slot changes.
- R4: A scope-0 request faults when descriptor bits [127:111] are not all equal. While `pcid_en` is low, a scope-0 or scope-1 request faults when descriptor bits [11:0] are nonzero.
- R5: Scope 0 clears every non-global slot whose context equals descriptor bits [11:0] and whose page, at that slot's own size, contains the address in descriptor bits [127:64]. This includes every one of several slots that cover that address.
- R6: Scope 1 clears every non-global slot whose context equals descriptor bits [11:0], whatever the address field holds.
- R7: Scope 2 clears every slot, global slots included.
- R8: Scope 3 clears every non-global slot and keeps global slots.
- R9: A sweep started while `pcid_en` is low clears only slots tagged with context 0.
- R10: A valid request holds `busy` high for exactly ENTRIES cycles, then pulses `inv_done` for one cycle. While `busy` is high, `lk_hit` is low and fills are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcid_en | input | 1 | Context tags enabled; when low, only context 0 is used |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Lookup linear address |
| lk_pcid | input | 12 | Lookup context |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Translated physical page number |
| fl_valid | input | 1 | Fill request |
| fl_addr | input | 64 | Fill linear address |
| fl_pcid | input | 12 | Fill context |
| fl_global | input | 1 | Fill global flag |
| fl_size | input | 2 | Fill page-size code |
| fl_ppn | input | PPN_W | Fill physical page number |
| inv_valid | input | 1 | Invalidation request, accepted while `busy` is low |
| inv_type | input | 64 | Scope selector value |
| inv_desc | input | 128 | Descriptor: context [11:0], reserved [63:12], address [127:64] |
| busy | output | 1 | Sweep in progress |
| inv_done | output | 1 | One-cycle pulse when a sweep ends |
| inv_fault | output | 1 | One-cycle pulse when a request is rejected |

## Verification
The bench builds the block with ENTRIES=4, VA_BITS=48 and PPN_W=28. With four slots, one crafted set fills the array exactly: a global 4 KiB slot, a 4 KiB slot and a 2 MiB slot that overlap the same address, and a 1 GiB context-0 slot at an upper-half address. This set is swept through every scope, two illegal selectors, both enable states, two descriptor contexts and two target addresses. A fifth fill into the full array then reaches the victim path, and the short sweep makes the exact busy length easy to count.

// File: rtl/pcid_tlb_pkg.sv
package pcid_tlb_pkg;

   localparam int CTX_W    = 12;
   localparam int PG_SHIFT = 12;
   localparam int LVL_BITS = 9;

   typedef enum logic [1:0] {
      PG_4K = 2'd0,
      PG_2M = 2'd1,
      PG_1G = 2'd2
   } pg_size_e;

   typedef enum logic [1:0] {
      SCOPE_ADDR     = 2'd0,
      SCOPE_CTX      = 2'd1,
      SCOPE_ALL      = 2'd2,
      SCOPE_ALL_KEEP = 2'd3
   } scope_e;

endpackage

// File: rtl/pcid_tlb_cmp.sv
module pcid_tlb_cmp
   import pcid_tlb_pkg::*;
#(
   parameter int VPN_W = 36,
   parameter int PPN_W = 28
) (
   input  logic [VPN_W-1:0] ent_vpn,
   input  logic [1:0]       ent_size,
   input  logic [PPN_W-1:0] ent_ppn,
   input  logic [VPN_W-1:0] q_vpn,
   output logic             vpn_eq,
   output logic [PPN_W-1:0] xlat_ppn
);

   localparam int MID_W = LVL_BITS;
   localparam int BIG_W = 2 * LVL_BITS;

   logic [VPN_W-1:0] ign;

   always_comb begin
      unique case (ent_size)
         PG_2M:   ign = {{(VPN_W-MID_W){1'b0}}, {MID_W{1'b1}}};
         PG_1G:   ign = {{(VPN_W-BIG_W){1'b0}}, {BIG_W{1'b1}}};
         default: ign = '0;
      endcase
   end

   assign vpn_eq   = ((ent_vpn ^ q_vpn) & ~ign) == '0;
   assign xlat_ppn = (ent_ppn & ~ign[PPN_W-1:0]) | (q_vpn[PPN_W-1:0] & ign[PPN_W-1:0]);

endmodule

// File: rtl/pcid_tlb_check.sv
module pcid_tlb_check
   import pcid_tlb_pkg::*;
#(
   parameter int VA_BITS = 48
) (
   input  logic [63:0]              op_type,
   input  logic [127:0]             op_desc,
   input  logic                     pcid_en,
   output logic                     fault,
   output logic [1:0]               scope,
   output logic [CTX_W-1:0]         op_pcid,
   output logic [VA_BITS-PG_SHIFT-1:0] op_vpn
);

   localparam int HI_LO = 64 + VA_BITS - 1;

   logic [127-HI_LO:0] hi_bits;
   logic bad_sel, rsvd_set, non_canon, ctx_forbidden;
   logic unused_desc;

   assign hi_bits       = op_desc[127:HI_LO];
   assign bad_sel       = |op_type[63:2];
   assign rsvd_set      = |op_desc[63:CTX_W];
   assign non_canon     = !((&hi_bits) || (~|hi_bits));
   assign scope         = op_type[1:0];
   assign op_pcid       = op_desc[CTX_W-1:0];
   assign op_vpn        = op_desc[64+VA_BITS-1:64+PG_SHIFT];
   assign ctx_forbidden = !pcid_en && !scope[1] && (|op_pcid);
   assign unused_desc   = ^op_desc[64+PG_SHIFT-1:64];

   assign fault = bad_sel | rsvd_set | ctx_forbidden
                | ((scope == SCOPE_ADDR) && non_canon);

endmodule

// File: rtl/pcid_tlb.sv
module pcid_tlb
   import pcid_tlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VA_BITS = 48,
   parameter int PPN_W   = 28
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pcid_en,
   input  logic               lk_valid,
   input  logic [63:0]        lk_addr,
   input  logic [11:0]        lk_pcid,
   output logic               lk_hit,
   output logic [PPN_W-1:0]   lk_ppn,
   input  logic               fl_valid,
   input  logic [63:0]        fl_addr,
   input  logic [11:0]        fl_pcid,
   input  logic               fl_global,
   input  logic [1:0]         fl_size,
   input  logic [PPN_W-1:0]   fl_ppn,
   input  logic               inv_valid,
   input  logic [63:0]        inv_type,
   input  logic [127:0]       inv_desc,
   output logic               busy,
   output logic               inv_done,
   output logic               inv_fault
);

   localparam int IDX_W = $clog2(ENTRIES);
   localparam int VPN_W = VA_BITS - PG_SHIFT;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   // elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("pcid_tlb: ENTRIES must be at least 2");
   end
   if (VA_BITS < 40 || VA_BITS > 63) begin : g_bad_va
      $error("pcid_tlb: VA_BITS out of range");
   end
   if (PPN_W < 2 * LVL_BITS + 1 || PPN_W > VPN_W) begin : g_bad_ppn
      $error("pcid_tlb: PPN_W must cover a 1 GiB offset and fit in VPN_W");
   end

   // slot storage
   logic [ENTRIES-1:0] v_q, g_q;
   logic [CTX_W-1:0]   ctx_q [ENTRIES];
   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [1:0]         sz_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q [ENTRIES];

   // sweep state
   logic              busy_q, done_q, fault_q, en_q;
   logic [IDX_W-1:0]  idx_q, vptr_q;
   logic [1:0]        scope_q;
   logic [CTX_W-1:0]  opctx_q;
   logic [VPN_W-1:0]  opvpn_q;

   logic unused_addr;
   assign unused_addr = ^{lk_addr[63:VA_BITS], lk_addr[PG_SHIFT-1:0],
                          fl_addr[63:VA_BITS], fl_addr[PG_SHIFT-1:0]};

   // lookup path
   logic [VPN_W-1:0]   lk_vpn;
   logic [CTX_W-1:0]   lk_ctx;
   logic [ENTRIES-1:0] lk_vec;
   logic [PPN_W-1:0]   lk_xl [ENTRIES];

   assign lk_vpn = lk_addr[VA_BITS-1:PG_SHIFT];
   assign lk_ctx = pcid_en ? lk_pcid : '0;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic eq;
      pcid_tlb_cmp #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_cmp (
         .ent_vpn  (vpn_q[i]),
         .ent_size (sz_q[i]),
         .ent_ppn  (ppn_q[i]),
         .q_vpn    (lk_vpn),
         .vpn_eq   (eq),
         .xlat_ppn (lk_xl[i])
      );
      assign lk_vec[i] = v_q[i] && (g_q[i] || ctx_q[i] == lk_ctx) && eq;
   end

   always_comb begin
      lk_ppn = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (lk_vec[i]) lk_ppn = lk_xl[i];
      end
   end

   assign lk_hit = lk_valid && !busy_q && (|lk_vec);

   // fill slot choice
   logic             fl_go, has_free;
   logic [IDX_W-1:0] fl_slot;

   assign fl_go = fl_valid && !busy_q;

   always_comb begin
      has_free = 1'b0;
      fl_slot  = vptr_q;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!v_q[i]) begin
            has_free = 1'b1;
            fl_slot  = IDX_W'(i);
         end
      end
   end

   // request check
   logic             chk_fault;
   logic [1:0]       chk_scope;
   logic [CTX_W-1:0] chk_ctx;
   logic [VPN_W-1:0] chk_vpn;
   logic             inv_go;

   pcid_tlb_check #(.VA_BITS(VA_BITS)) u_check (
      .op_type (inv_type),
      .op_desc (inv_desc),
      .pcid_en (pcid_en),
      .fault   (chk_fault),
      .scope   (chk_scope),
      .op_pcid (chk_ctx),
      .op_vpn  (chk_vpn)
   );

   assign inv_go = inv_valid && !busy_q;

   // sweep compare on the visited slot
   logic             sw_eq, sw_hit, sw_ctx_ok;
   logic [PPN_W-1:0] sw_xl_unused;

   pcid_tlb_cmp #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_sweep_cmp (
      .ent_vpn  (vpn_q[idx_q]),
      .ent_size (sz_q[idx_q]),
      .ent_ppn  (ppn_q[idx_q]),
      .q_vpn    (opvpn_q),
      .vpn_eq   (sw_eq),
      .xlat_ppn (sw_xl_unused)
   );

   assign sw_ctx_ok = en_q || (ctx_q[idx_q] == '0);

   always_comb begin
      unique case (scope_q)
         SCOPE_ADDR: sw_hit = !g_q[idx_q] && ctx_q[idx_q] == opctx_q && sw_eq;
         SCOPE_CTX:  sw_hit = !g_q[idx_q] && ctx_q[idx_q] == opctx_q;
         SCOPE_ALL:  sw_hit = 1'b1;
         default:    sw_hit = !g_q[idx_q];
      endcase
   end

   // control and valid bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q     <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         en_q    <= 1'b0;
         idx_q   <= '0;
         vptr_q  <= '0;
         scope_q <= SCOPE_ALL;
         opctx_q <= '0;
         opvpn_q <= '0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         if (fl_go) begin
            v_q[fl_slot] <= 1'b1;
            if (!has_free) vptr_q <= (vptr_q == LAST) ? '0 : vptr_q + 1'b1;
         end
         if (inv_go) begin
            if (chk_fault) begin
               fault_q <= 1'b1;
            end else begin
               busy_q  <= 1'b1;
               idx_q   <= '0;
               scope_q <= chk_scope;
               opctx_q <= chk_ctx;
               opvpn_q <= chk_vpn;
               en_q    <= pcid_en;
            end
         end
         if (busy_q) begin
            if (sw_hit && sw_ctx_ok) v_q[idx_q] <= 1'b0;
            if (idx_q == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   // slot payload, no reset needed
   always_ff @(posedge clk) begin
      if (fl_go) begin
         g_q[fl_slot]   <= fl_global;
         ctx_q[fl_slot] <= pcid_en ? fl_pcid : '0;
         vpn_q[fl_slot] <= fl_addr[VA_BITS-1:PG_SHIFT];
         sz_q[fl_slot]  <= fl_size;
         ppn_q[fl_slot] <= fl_ppn;
      end
   end

   assign busy      = busy_q;
   assign inv_done  = done_q;
   assign inv_fault = fault_q;

   // assertions
   assert_no_hit_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !lk_hit);
   assert_done_ends_sweep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      inv_done |-> ($past(busy) && !busy));
   assert_sweep_only_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ((v_q & ~$past(v_q)) == '0));
   assert_fault_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      inv_fault |-> (!busy && !inv_done && $past(inv_valid && !busy)));
   assert_bad_sel_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !busy && (|inv_type[63:2])) |=> inv_fault);
   assert_noncanon_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !busy && inv_type == 64'd0 &&
       !((&inv_desc[127:64+VA_BITS-1]) || (~|inv_desc[127:64+VA_BITS-1]))) |=> inv_fault);

endmodule

// File: tb/pcid_tlb_tb.sv
module pcid_tlb_tb;

   localparam int N  = 4;
   localparam int VA = 48;
   localparam int PW = 28;
   localparam int VW = VA - 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pcid_en = 1'b1;
   logic          lk_valid = 1'b0;
   logic [63:0]   lk_addr = '0;
   logic [11:0]   lk_pcid = '0;
   logic          lk_hit;
   logic [PW-1:0] lk_ppn;
   logic          fl_valid = 1'b0;
   logic [63:0]   fl_addr = '0;
   logic [11:0]   fl_pcid = '0;
   logic          fl_global = 1'b0;
   logic [1:0]    fl_size = '0;
   logic [PW-1:0] fl_ppn = '0;
   logic          inv_valid = 1'b0;
   logic [63:0]   inv_type = '0;
   logic [127:0]  inv_desc = '0;
   logic          busy, inv_done, inv_fault;

   always #4 clk = ~clk;

   pcid_tlb #(.ENTRIES(N), .VA_BITS(VA), .PPN_W(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .pcid_en(pcid_en),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_pcid(lk_pcid),
      .lk_hit(lk_hit), .lk_ppn(lk_ppn),
      .fl_valid(fl_valid), .fl_addr(fl_addr), .fl_pcid(fl_pcid),
      .fl_global(fl_global), .fl_size(fl_size), .fl_ppn(fl_ppn),
      .inv_valid(inv_valid), .inv_type(inv_type), .inv_desc(inv_desc),
      .busy(busy), .inv_done(inv_done), .inv_fault(inv_fault)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // reference model
   bit            mv [N];
   bit            mg [N];
   logic [11:0]   mp [N];
   logic [VW-1:0] mvpn [N];
   logic [1:0]    msz [N];
   logic [PW-1:0] mppn [N];
   int            vptr = 0;

   localparam logic [63:0] A = 64'h0000_0012_3456_7000;
   localparam logic [63:0] B = 64'hFFFF_FFC0_4000_0000;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [VW-1:0] ign_mask(logic [1:0] s);
      if (s == 2'd1) return VW'(36'h1FF);
      if (s == 2'd2) return VW'(36'h3FFFF);
      return '0;
   endfunction

   task automatic probe(string req, logic [63:0] a, logic [11:0] p);
      logic [VW-1:0] q;
      logic [PW-1:0] ep;
      bit eh;
      q  = a[VA-1:12];
      eh = 1'b0;
      ep = '0;
      for (int i = N - 1; i >= 0; i--) begin
         logic [VW-1:0] m;
         m = ign_mask(msz[i]);
         if (mv[i] && (mg[i] || mp[i] == p) && (((mvpn[i] ^ q) & ~m) == '0)) begin
            eh = 1'b1;
            ep = (mppn[i] & ~m[PW-1:0]) | (q[PW-1:0] & m[PW-1:0]);
         end
      end
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = a; lk_pcid = p;
      #1;
      chk(req, 64'(lk_hit), 64'(eh), "lookup hit");
      if (eh) chk(req, 64'(lk_ppn), 64'(ep), "lookup ppn");
      lk_valid = 1'b0;
   endtask

   task automatic fill(logic [63:0] a, logic [11:0] p, bit g, logic [1:0] s, logic [PW-1:0] pp);
      int slot;
      slot = -1;
      for (int i = N - 1; i >= 0; i--) if (!mv[i]) slot = i;
      if (slot < 0) begin
         slot = vptr;
         vptr = (vptr + 1) % N;
      end
      mv[slot] = 1'b1; mg[slot] = g; mp[slot] = pcid_en ? p : 12'h000;
      mvpn[slot] = a[VA-1:12]; msz[slot] = s; mppn[slot] = pp;
      @(negedge clk);
      fl_valid = 1'b1; fl_addr = a; fl_pcid = p; fl_global = g; fl_size = s; fl_ppn = pp;
      @(negedge clk);
      fl_valid = 1'b0;
   endtask

   task automatic inv(string req, logic [63:0] t, logic [127:0] d);
      bit ef, hit;
      logic [16:0] hi;
      logic [VW-1:0] q;
      int n;
      hi = d[127:111];
      q  = d[64+VA-1:76];
      ef = (t > 64'd3) || (d[63:12] != '0) ||
           (t == 64'd0 && !((&hi) || (~|hi))) ||
           (!pcid_en && t <= 64'd1 && d[11:0] != 12'h000);
      @(negedge clk);
      inv_valid = 1'b1; inv_type = t; inv_desc = d;
      @(negedge clk);
      inv_valid = 1'b0;
      chk(req, 64'(inv_fault), 64'(ef), "fault pulse");
      if (ef) begin
         chk(req, 64'(busy), 64'd0, "busy after fault");
         @(negedge clk);
         chk(req, 64'(inv_fault), 64'd0, "fault is one cycle");
      end else begin
         chk("R10", 64'(busy), 64'd1, "busy after accept");
         n = 0;
         while (!inv_done && n < 50) begin
            @(negedge clk);
            n++;
         end
         chk("R10", 64'(n), 64'(N), "sweep length");
         chk("R10", 64'(busy), 64'd0, "busy at done");
         for (int i = 0; i < N; i++) begin
            if (mv[i] && (pcid_en || mp[i] == 12'h000)) begin
               case (t[1:0])
                  2'd0: hit = !mg[i] && mp[i] == d[11:0] &&
                              (((mvpn[i] ^ q) & ~ign_mask(msz[i])) == '0);
                  2'd1: hit = !mg[i] && mp[i] == d[11:0];
                  2'd2: hit = 1'b1;
                  default: hit = !mg[i];
               endcase
               if (hit) mv[i] = 1'b0;
            end
         end
      end
   endtask

   function automatic string tag_for(logic [63:0] t, bit en);
      if (t > 64'd3) return "R3";
      if (!en && t >= 64'd2) return "R9";
      if (t == 64'd0) return "R5";
      if (t == 64'd1) return "R6";
      if (t == 64'd2) return "R7";
      return "R8";
   endfunction

   task automatic load_set();
      fill(A + 64'h2000, 12'h005, 1'b1, 2'd0, 28'h000_0011);
      fill(A,            12'h005, 1'b0, 2'd0, 28'h000_0022);
      fill(A,            12'h005, 1'b0, 2'd1, 28'h000_3400);
      fill(B,            12'h000, 1'b0, 2'd2, 28'h0C0_0000);
   endtask

   task automatic probe_all(string req);
      logic [63:0] pa [4];
      logic [11:0] pc [3];
      pa = '{A, A + 64'h1000, A + 64'h2000, B + 64'h1234_5000};
      pc = '{12'h000, 12'h005, 12'h009};
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 3; j++)
            probe(req, pa[i], pc[j]);
   endtask

   initial begin
      logic [63:0] types [6];
      logic [11:0] pids [2];
      logic [63:0] tgt [2];
      types = '{64'd0, 64'd1, 64'd2, 64'd3, 64'd4, 64'h0000_0100_0000_0001};
      pids  = '{12'h000, 12'h005};
      tgt   = '{A, A + 64'h2000};
      for (int i = 0; i < N; i++) mv[i] = 1'b0;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", 64'(busy), 64'd0, "busy in reset");
      chk("R1", 64'(inv_done), 64'd0, "done in reset");
      chk("R1", 64'(inv_fault), 64'd0, "fault in reset");
      @(negedge clk) rst_n = 1'b1;
      probe("R1", A, 12'h005);
      probe("R1", B, 12'h000);

      // R2: fill and lookup, size masking, context 0 mode
      load_set();
      probe_all("R2");
      inv("R7", 64'd2, 128'd0);
      pcid_en = 1'b0;
      fill(A, 12'h005, 1'b0, 2'd0, 28'h000_0777);
      pcid_en = 1'b1;
      probe("R2", A, 12'h000);
      probe("R2", A, 12'h005);
      inv("R7", 64'd2, 128'd0);

      // sweep over scope x enable x context x target
      foreach (types[ti])
         for (int en = 0; en < 2; en++)
            foreach (pids[pi])
               foreach (tgt[ai]) begin
                  string tg;
                  pcid_en = 1'b1;
                  inv("R7", 64'd2, 128'd0);
                  load_set();
                  pcid_en = en[0];
                  tg = tag_for(types[ti], en[0]);
                  if (!en[0] && types[ti] <= 64'd1 && pids[pi] != 0) tg = "R4";
                  inv(tg, types[ti], {tgt[ai], 52'd0, pids[pi]});
                  pcid_en = 1'b1;
                  probe_all(tg);
               end

      // R3 / R4 / R6: descriptor rule corners
      inv("R7", 64'd2, 128'd0);
      load_set();
      inv("R3", 64'd3, {64'd0, 52'h0_0000_0000_0001, 12'h000});
      inv("R3", 64'd2, {64'd0, 1'b1, 51'd0, 12'h000});
      probe_all("R3");
      inv("R4", 64'd0, {64'h0000_8012_3456_7000, 52'd0, 12'h005});
      inv("R4", 64'd0, {64'hFFFF_0012_3456_7000, 52'd0, 12'h005});
      probe_all("R4");
      inv("R6", 64'd1, {64'h0000_8012_3456_7000, 52'd0, 12'h005});
      probe_all("R6");

      // R10: stall during sweep
      inv("R7", 64'd2, 128'd0);
      load_set();
      @(negedge clk);
      inv_valid = 1'b1; inv_type = 64'd3; inv_desc = '0;
      @(negedge clk);
      inv_valid = 1'b0;
      lk_valid = 1'b1; lk_addr = A + 64'h2000; lk_pcid = 12'h005;
      fl_valid = 1'b1; fl_addr = 64'h0000_0000_0055_5000; fl_pcid = 12'h005;
      fl_global = 1'b1; fl_size = 2'd0; fl_ppn = 28'h55;
      #1;
      chk("R10", 64'(busy), 64'd1, "busy during sweep");
      chk("R10", 64'(lk_hit), 64'd0, "lookup stalled");
      @(negedge clk);
      fl_valid = 1'b0; lk_valid = 1'b0;
      while (!inv_done) @(negedge clk);
      for (int i = 0; i < N; i++) if (!mg[i]) mv[i] = 1'b0;
      probe("R10", 64'h0000_0000_0055_5000, 12'h005);
      probe("R8", A + 64'h2000, 12'h009);

      // R2: victim replacement when full
      inv("R7", 64'd2, 128'd0);
      for (int k = 0; k < 5; k++)
         fill(64'h0000_0000_1000_0000 + 64'(k) * 64'h1000, 12'h005, 1'b0, 2'd0, PW'(k + 1));
      for (int k = 0; k < 5; k++)
         probe("R2", 64'h0000_0000_1000_0000 + 64'(k) * 64'h1000, 12'h005);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R10 watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule